// File: doc/BRIEF.md
# Frame-Gap Deserializer

This block sits on the receive side of a low-rate serial link, after the stage that decides whether each bit time carried usable data. Each bit time arrives as a one-cycle strobe with a data bit and a qualifier that marks the bit as valid or not. In packed mode the block gathers valid bits into bytes, most significant bit first, and hands each finished byte to a data register that the host reads.

The end of a frame is found from silence. Once a frame holds at least one valid bit, the block counts the bit times in a row that carry no valid data. When that count reaches a programmable gap length it raises an end-of-frame event. The event moves any partial byte, with its bit count, into the data register. It also sets a level interrupt, which stays high until the host clears it.

A control register selects between packed mode and a raw pass-through mode, and it also holds the gap length. In raw mode each qualified bit is forwarded one cycle later and the packing logic stays idle.

Top module: `rx_frame_deser`

## Requirements
- R1: After reset `ctl_q` reads 0x03 (packed mode off, gap length 3). A write through `ctl_we` keeps only bits 3:0 of `ctl_wdata`, so bits 7:4 of `ctl_q` always read zero. Bit 3 is the packed-mode enable and bits 2:0 are the gap length L.
- R2: With bit 3 clear (raw mode), the cycle after a strobe with `bit_val` high shows `ser_vld`=1 and `ser_dat`=`bit_dat`, and `ser_vld`/`ser_dat` are 0 in every other case. In raw mode no byte is packed and `eof_pulse` stays 0. In packed mode `ser_vld` and `ser_dat` stay 0.
- R3: In packed mode each valid strobed bit is shifted in MSB first. The cycle after the eighth valid bit, `rx_byte` holds the byte, `rx_nbits`=8 and `rx_avail`=1.
- R4: A cycle with `data_rd` high clears `rx_avail` at the next edge. If a new byte or partial byte is stored in that same cycle, `rx_avail` stays 1.
- R5: No end-of-frame event occurs unless a valid bit has arrived since reset, since the last event, or since packed mode was last entered.
- R6: Once armed, the end-of-frame event happens on the strobe that has the invalid flag and finds at least L earlier invalid bit times in a row. With L=0 this is the first invalid bit. `eof_pulse` is high for exactly the cycle after that strobe.
- R7: A valid bit that arrives while the gap count is running sets the count back to zero and does not end the frame.
- R8: At end of frame, a partial byte of k bits (1..7) is stored right-aligned in `rx_byte`, with `rx_nbits`=k and `rx_avail`=1. If no bits are pending, `rx_byte` and `rx_nbits` are left unchanged.
- R9: After an end-of-frame event, further invalid bits raise no new event until a valid bit arrives.
- R10: `irq` goes to 1 the cycle after an end-of-frame event and holds until a cycle with `sts_wr`=1 and `sts_w1c`=1. If an event and a clear fall in the same cycle, the event wins.
- R11: Cycles with `bit_stb` low leave the packing, gap and raw-output state unaffected, whatever `bit_val` and `bit_dat` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register contents |
| bit_stb | input | 1 | Bit-time strobe |
| bit_val | input | 1 | Bit qualifier, 1 = valid data |
| bit_dat | input | 1 | Received data bit |
| ser_vld | output | 1 | Raw-mode forwarded bit valid |
| ser_dat | output | 1 | Raw-mode forwarded bit |
| data_rd | input | 1 | Host read of the data register |
| rx_byte | output | 8 | Data register |
| rx_nbits | output | 4 | Valid bits held in `rx_byte` |
| rx_avail | output | 1 | Data register holds unread data |
| eof_pulse | output | 1 | One-cycle end-of-frame event |
| sts_wr | input | 1 | Status write strobe |
| sts_w1c | input | 1 | Status write data; 1 clears `irq` |
| irq | output | 1 | End-of-frame interrupt level |

## Verification
The hardest cases to reach from the ports are a valid bit landing on the last bit time before the gap would expire, and an end-of-frame event colliding with an interrupt clear or a data read. The bench drives these with directed sequences at chosen gap lengths, including zero. It then runs a long random stream of strobes, qualifiers, reads and mode changes. A behavioural model built from a bit queue and integer counters is compared with every output on every cycle.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  localparam int unsigned RFD_DATA_W  = 8;
  localparam int unsigned RFD_GAP_W   = 3;
  localparam int unsigned RFD_CTL_W   = 8;
  localparam logic [7:0]  RFD_CTL_RST = 8'h03;
  localparam int unsigned RFD_SYNC_N  = 2;
endpackage

// File: rtl/rfd_rst_sync.sv
module rfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rfd_ctl_reg.sv
module rfd_ctl_reg #(
  parameter int unsigned       CTL_W   = 8,
  parameter int unsigned       GAP_W   = 3,
  parameter logic [CTL_W-1:0]  RST_VAL = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] ctl_q,
  output logic             pk_mode,
  output logic [GAP_W-1:0] gap_len
);
  localparam logic [CTL_W-1:0] WMASK = CTL_W'((1 << (GAP_W + 1)) - 1);

  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wr_data & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= RST_VAL & WMASK;
    else if (wr_en) ctl_q <= ctl_d;
  end

  assign pk_mode = ctl_q[GAP_W];
  assign gap_len = ctl_q[GAP_W-1:0];
endmodule

// File: rtl/rfd_gap_det.sv
module rfd_gap_det #(
  parameter int unsigned GAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             stb,
  input  logic             val,
  input  logic [GAP_W-1:0] gap_len,
  output logic             eof,
  output logic             eof_q
);
  logic             armed_q, armed_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             ev;
  logic             ce;

  always_comb begin
    ev      = en & stb;
    eof     = ev & ~val & armed_q & (gap_q >= gap_len);
    armed_d = armed_q;
    gap_d   = gap_q;
    if (!en) begin
      armed_d = 1'b0;
      gap_d   = '0;
    end else if (ev && val) begin
      armed_d = 1'b1;
      gap_d   = '0;
    end else if (ev && armed_q) begin
      if (eof) begin
        armed_d = 1'b0;
        gap_d   = '0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
    ce = ~en | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (ce) begin
      armed_q <= armed_d;
      gap_q   <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eof_q <= 1'b0;
    else        eof_q <= eof;
  end
endmodule

// File: rtl/rfd_packer.sv
module rfd_packer #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              shift,
  input  logic              din,
  input  logic              eof,
  input  logic              rd,
  output logic [DATA_W-1:0] dat_q,
  output logic [CNT_W-1:0]  nb_q,
  output logic              av_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_d, dat_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, nb_d;
  logic              av_d;
  logic              store, sh_ce, av_ce;
  logic [DATA_W-1:0] sh_next;

  always_comb begin
    sh_next = {sh_q[DATA_W-2:0], din};
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    dat_d   = dat_q;
    nb_d    = nb_q;
    store   = 1'b0;
    if (!en) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift) begin
      if (cnt_q == LAST) begin
        dat_d = sh_next;
        nb_d  = FULL;
        store = 1'b1;
        sh_d  = '0;
        cnt_d = '0;
      end else begin
        sh_d  = sh_next;
        cnt_d = cnt_q + 1'b1;
      end
    end else if (eof) begin
      if (cnt_q != '0) begin
        dat_d = sh_q;
        nb_d  = cnt_q;
        store = 1'b1;
      end
      sh_d  = '0;
      cnt_d = '0;
    end
    av_d  = store ? 1'b1 : (rd ? 1'b0 : av_q);
    sh_ce = ~en | shift | eof;
    av_ce = store | rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_ce) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      nb_q  <= '0;
    end else if (store) begin
      dat_q <= dat_d;
      nb_q  <= nb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     av_q <= 1'b0;
    else if (av_ce) av_q <= av_d;
  end
endmodule

// File: rtl/rx_frame_deser.sv
module rx_frame_deser
  import rfd_pkg::*;
#(
  parameter int unsigned      DATA_W  = RFD_DATA_W,
  parameter int unsigned      GAP_W   = RFD_GAP_W,
  parameter int unsigned      CTL_W   = RFD_CTL_W,
  parameter logic [CTL_W-1:0] CTL_RST = RFD_CTL_RST,
  parameter int unsigned      SYNC_N  = RFD_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              bit_dat,
  output logic              ser_vld,
  output logic              ser_dat,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_byte,
  output logic [$clog2(DATA_W+1)-1:0] rx_nbits,
  output logic              rx_avail,
  output logic              eof_pulse,
  input  logic              sts_wr,
  input  logic              sts_w1c,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic             srst_n;
  logic             pk_mode;
  logic [GAP_W-1:0] gap_len;
  logic             eof;
  logic             shift;
  logic             irq_d, irq_ce;
  logic             sv_d, sd_d;

  rfd_rst_sync #(.STAGES(SYNC_N)) rst_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rfd_ctl_reg #(.CTL_W(CTL_W), .GAP_W(GAP_W), .RST_VAL(CTL_RST)) ctl_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (ctl_we),
    .wr_data (ctl_wdata),
    .ctl_q   (ctl_q),
    .pk_mode (pk_mode),
    .gap_len (gap_len)
  );

  rfd_gap_det #(.GAP_W(GAP_W)) gap_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .en      (pk_mode),
    .stb     (bit_stb),
    .val     (bit_val),
    .gap_len (gap_len),
    .eof     (eof),
    .eof_q   (eof_pulse)
  );

  assign shift = pk_mode & bit_stb & bit_val;

  rfd_packer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) pack_i (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (pk_mode),
    .shift (shift),
    .din   (bit_dat),
    .eof   (eof),
    .rd    (data_rd),
    .dat_q (rx_byte),
    .nb_q  (rx_nbits),
    .av_q  (rx_avail)
  );

  always_comb begin
    irq_d  = eof ? 1'b1 : ((sts_wr & sts_w1c) ? 1'b0 : irq);
    irq_ce = eof | (sts_wr & sts_w1c);
    sv_d   = ~pk_mode & bit_stb & bit_val;
    sd_d   = sv_d & bit_dat;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     irq <= 1'b0;
    else if (irq_ce) irq <= irq_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ser_vld <= 1'b0;
      ser_dat <= 1'b0;
    end else begin
      ser_vld <= sv_d;
      ser_dat <= sd_d;
    end
  end
endmodule

// File: rtl/rfd_chk.sv
module rfd_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GAP_W  = 3,
  parameter int unsigned CTL_W  = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTL_W-1:0] ctl_q,
  input logic             bit_stb,
  input logic             bit_val,
  input logic             data_rd,
  input logic             sts_wr,
  input logic             sts_w1c,
  input logic             eof_pulse,
  input logic             irq,
  input logic             ser_vld,
  input logic             rx_avail,
  input logic [CNT_W-1:0] rx_nbits
);
  // R1
  ctl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_W-1:GAP_W+1] == '0);

  // R6
  eof_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> $past(bit_stb && !bit_val && ctl_q[GAP_W]));

  // R2
  raw_no_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[GAP_W] |=> !eof_pulse);

  // R2
  pk_no_ser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[GAP_W] |=> !ser_vld);

  // R10
  irq_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> irq);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(sts_wr && sts_w1c)) |=> irq);

  // R8
  nbits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail |-> (rx_nbits != '0 && rx_nbits <= CNT_W'(DATA_W)));

  // R4
  avail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_avail) |-> $past(data_rd));
endmodule

bind rx_frame_deser rfd_chk #(
  .DATA_W (DATA_W),
  .GAP_W  (GAP_W),
  .CTL_W  (CTL_W),
  .CNT_W  ($clog2(DATA_W + 1))
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_q     (ctl_q),
  .bit_stb   (bit_stb),
  .bit_val   (bit_val),
  .data_rd   (data_rd),
  .sts_wr    (sts_wr),
  .sts_w1c   (sts_w1c),
  .eof_pulse (eof_pulse),
  .irq       (irq),
  .ser_vld   (ser_vld),
  .rx_avail  (rx_avail),
  .rx_nbits  (rx_nbits)
);

// File: tb/rx_frame_deser_tb_top.sv
`timescale 1ns/1ps
module rx_frame_deser_tb_top;
  logic       clk;
  logic       rst_n;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_q;
  logic       bit_stb, bit_val, bit_dat;
  logic       ser_vld, ser_dat;
  logic       data_rd;
  logic [7:0] rx_byte;
  logic [3:0] rx_nbits;
  logic       rx_avail, eof_pulse;
  logic       sts_wr, sts_w1c;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  rx_frame_deser dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_dat(bit_dat),
    .ser_vld(ser_vld), .ser_dat(ser_dat), .data_rd(data_rd),
    .rx_byte(rx_byte), .rx_nbits(rx_nbits), .rx_avail(rx_avail),
    .eof_pulse(eof_pulse), .sts_wr(sts_wr), .sts_w1c(sts_w1c), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int m_ctl, m_gap, m_byte, m_nb;
  bit m_armed, m_av, m_irq, m_eof, m_sv, m_so;
  bit mq[$];

  function automatic int pack_q();
    int v = 0;
    foreach (mq[i]) v = (v << 1) | int'(mq[i]);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 3; m_gap = 0; m_byte = 0; m_nb = 0;
      m_armed = 0; m_av = 0; m_irq = 0; m_eof = 0; m_sv = 0; m_so = 0;
      mq.delete();
    end else begin
      bit pk, eofn, st;
      int len;
      pk = m_ctl[3]; len = m_ctl & 7; eofn = 0; st = 0;
      if (pk) begin
        if (bit_stb && bit_val) begin
          mq.push_back(bit_dat); m_armed = 1; m_gap = 0;
          if (mq.size() == 8) begin
            m_byte = pack_q(); m_nb = 8; st = 1; mq.delete();
          end
        end else if (bit_stb && m_armed) begin
          if (m_gap >= len) begin
            eofn = 1;
            if (mq.size() > 0) begin
              m_byte = pack_q(); m_nb = mq.size(); st = 1;
            end
            mq.delete(); m_armed = 0; m_gap = 0;
          end else m_gap++;
        end
      end else begin
        mq.delete(); m_armed = 0; m_gap = 0;
      end
      if (st) m_av = 1; else if (data_rd) m_av = 0;
      if (eofn) m_irq = 1; else if (sts_wr && sts_w1c) m_irq = 0;
      m_eof = eofn;
      m_sv  = !pk && bit_stb && bit_val;
      m_so  = m_sv && bit_dat;
      if (ctl_we) m_ctl = ctl_wdata & 8'h0f;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 ctl_q", ctl_q, m_ctl);
      chk("R2 ser_vld", ser_vld, m_sv);
      chk("R2 ser_dat", ser_dat, m_so);
      chk("R3/R8 rx_byte", rx_byte, m_byte);
      chk("R3/R8 rx_nbits", rx_nbits, m_nb);
      chk("R4 rx_avail", rx_avail, m_av);
      chk("R6 eof_pulse", eof_pulse, m_eof);
      chk("R10 irq", irq, m_irq);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle_inputs();
    ctl_we = 0; ctl_wdata = 0; bit_stb = 0; bit_val = 0; bit_dat = 0;
    data_rd = 0; sts_wr = 0; sts_w1c = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic tick(input bit v, input bit d);
    bit_stb = 1; bit_val = v; bit_dat = d;
    step();
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v;
    step();
  endtask

  task automatic junk();
    bit_stb = 0; bit_val = 1; bit_dat = 1;
    step();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    repeat (5) step();

    // R1 reset state
    chk("R1 reset ctl", ctl_q, 8'h03);
    chk("R1 reset avail", rx_avail, 0);
    chk("R10 reset irq", irq, 0);

    // R2 raw mode pass-through
    tick(1, 1); chk("R2 raw vld", ser_vld, 1); chk("R2 raw dat", ser_dat, 1);
    tick(0, 1); chk("R2 raw invalid", ser_vld, 0);
    repeat (6) begin tick(0, 0); chk("R2 raw no eof", eof_pulse, 0); end

    // R1 reserved bits dropped; packed, L=0
    wr_ctl(8'hF8); chk("R1 masked write", ctl_q, 8'h08);

    // R3 + R11: 0xA5 MSB first with idle junk between strobes
    for (int i = 7; i >= 0; i--) begin
      tick(1, (8'hA5 >> i) & 1); junk();
    end
    chk("R3 byte", rx_byte, 8'hA5); chk("R3 nbits", rx_nbits, 8); chk("R3 avail", rx_avail, 1);
    chk("R11 no eof on junk", eof_pulse, 0);
    data_rd = 1; step(); chk("R4 read clears", rx_avail, 0);

    // R6/R8 L=0: 3 bits then first invalid ends frame
    tick(1, 1); tick(1, 0); tick(1, 1);
    tick(0, 0);
    chk("R6 eof L0", eof_pulse, 1); chk("R8 partial", rx_byte, 5);
    chk("R8 count", rx_nbits, 3); chk("R10 irq set", irq, 1);
    tick(0, 0); chk("R9 disarmed", eof_pulse, 0); chk("R10 irq held", irq, 1);
    sts_wr = 1; sts_w1c = 0; step(); chk("R10 zero write keeps", irq, 1);
    sts_wr = 1; sts_w1c = 1; step(); chk("R10 clear", irq, 0);

    // R7 and R6 at L=3
    data_rd = 1; wr_ctl(8'h0B);
    tick(1, 1); tick(1, 1);
    repeat (3) begin tick(0, 0); chk("R6 no early eof", eof_pulse, 0); end
    tick(1, 0); chk("R7 valid restarts", eof_pulse, 0);
    repeat (3) begin tick(0, 0); chk("R7 gap restarted", eof_pulse, 0); end
    tick(0, 0); chk("R6 eof L3", eof_pulse, 1);
    chk("R8 partial L3", rx_byte, 6); chk("R8 count L3", rx_nbits, 3);
    repeat (10) begin tick(0, 0); chk("R9 no repeat eof", eof_pulse, 0); end

    // R5: raw then packed again, invalid bits only
    wr_ctl(8'h03); tick(1, 1); wr_ctl(8'h08);
    repeat (5) begin tick(0, 0); chk("R5 no eof unarmed", eof_pulse, 0); end

    // R10 event and clear together: event wins
    sts_wr = 1; sts_w1c = 1; step();
    tick(1, 0);
    sts_wr = 1; sts_w1c = 1; tick(0, 0);
    chk("R10 set wins", irq, 1); chk("R8 one bit", rx_nbits, 1);

    // R4 byte completes while read
    for (int i = 0; i < 7; i++) tick(1, i[0]);
    data_rd = 1; tick(1, 1);
    chk("R4 set wins", rx_avail, 1); chk("R3 byte2", rx_byte, 8'h55);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit_stb = ($urandom % 2) == 0;
      bit_val = ($urandom % 5) != 0;
      bit_dat = $urandom % 2;
      data_rd = ($urandom % 10) == 0;
      sts_wr  = ($urandom % 20) == 0;
      sts_w1c = $urandom % 2;
      if (($urandom % 100) == 0) begin ctl_we = 1; ctl_wdata = 8'($urandom); end
      step();
    end
    repeat (4) step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule